// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot registers of a downstream port that supports hot-plug. These are the slot capability, slot control and slot status registers, plus the interrupt message number. Software reaches them through a small configuration window: writes carry byte enables, and read data is returned combinationally for the addressed dword. On the physical side, the block takes single-cycle pulses for four things: a device already present at power-up (cold plug), a device inserted, a device removed, and an attention-button press.

Every write that touches the slot control halfword counts as one command. The command completes at once and sets the command-completed status bit. The block keeps track of whether a hot-plug interrupt is pending. When that condition changes, it raises a one-cycle message request with the stored vector if a message mode is enabled. Otherwise it drives a level INTx line. A write of 1 to the interlock control bit flips the interlock status. While the interlock is engaged, insert and remove requests are refused with a busy pulse.

Top module: `slot_hp_ctrl`

## Requirements
- R1: After reset, dword 2 reads 0x000003C0: both indicator fields (control bits 7:6 and 9:8) hold the off encoding 2'b11, all enables are 0 and all status bits are 0. The message request and INTx outputs are low.
- R2: Software can change only control bits 0 (button enable), 3 (presence-change enable), 4 (command enable), 5 (hot-plug interrupt enable) and 9:6 (indicators). All other control bits read 0.
- R3: A write to dword 2 with byte enable 0 or 1 set sets status bit 4 (command completed, read bit 20) in the following cycle. A write that enables only bytes 2 and 3 does not set it.
- R4: Writing 1 to control bit 11 (interlock control) with byte enable 1 inverts status bit 7 (interlock engaged, read bit 23). Control bit 11 always reads 0.
- R5: Status bits 0, 3 and 4 are cleared by writing 1 to them. A 1 written to status bit 6 or 7 has no effect.
- R6: A cold-plug pulse sets status bit 6 (presence state) and leaves status bit 3 (presence changed) clear.
- R7: An insert pulse sets status bits 6 and 3. A remove pulse clears bit 6 and sets bit 3. An attention-button pulse sets status bit 0.
- R8: While status bit 7 is set, an insert or remove pulse raises plugBusy in the next cycle and changes no status bit.
- R9: Pending means control bit 5 is set and (status AND control AND 0x0019) is nonzero. When pending rises and msiEn or msixEn is high, msgReq pulses for exactly one cycle, one cycle after the register update, with msgVector equal to MSG_VECTOR.
- R10: With both message modes off, intxOut follows the pending condition. It falls after a status clear write ends the pending condition.
- R11: An event whose status bit is already set produces no message. A pending condition ended by a status clear write produces no message.
- R12: An event that arrives while its enables are off produces exactly one message once software sets the enables.
- R13: Dword 0 reads MSG_VECTOR in bits 4:0. Dword 1 reads the slot number in bits 12:0 and the capability flags in bits 21:16, all set. Dword 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W | Dword index for read and write |
| cfgByteEn | input | 4 | Write byte enables |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for cfgAddr |
| coldPlug | input | 1 | Device present at power-up |
| hotAdd | input | 1 | Device inserted |
| hotRemove | input | 1 | Device removed |
| attnPress | input | 1 | Attention button pressed |
| msiEn | input | 1 | Message interrupt mode enabled |
| msixEn | input | 1 | Extended message interrupt mode enabled |
| plugBusy | output | 1 | Insert/remove refused because interlock engaged |
| msgReq | output | 1 | One-cycle message interrupt request |
| msgVector | output | VEC_W | Vector sent with msgReq |
| intxOut | output | 1 | Level legacy interrupt |

## Verification
The pending logic is exercised in four ways:
- An insert raises it in message mode. This separates a pulse on a change from a level output.
- Repeated events on an already-set status bit show that nothing fires again while the condition is unchanged.
- A status clear write ends the condition. This shows that a fall caused by clearing is silent in message mode, yet still lowers INTx in legacy mode.
- An event arrives with the enables off, and the enables are written afterwards. This shows the deferred notification.

Separate register-level patterns cover the other cases: writes that touch only the control bytes or only the status bytes, writes that flip the interlock, and insert pulses while the interlock is engaged. These separate command side effects from write-1-to-clear and from refusal.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

  // dword indices of the register window
  localparam int REG_ID   = 0;
  localparam int REG_CAP  = 1;
  localparam int REG_SLOT = 2;

  // slot control bit positions (enables line up with the status bits they gate)
  localparam int CTL_ABP_EN  = 0;
  localparam int CTL_PDC_EN  = 3;
  localparam int CTL_CC_EN   = 4;
  localparam int CTL_HP_IE   = 5;
  localparam int CTL_ATTN_LO = 6;
  localparam int CTL_PWR_LO  = 8;
  localparam int CTL_LOCK    = 11;

  // slot status bit positions
  localparam int STA_ABP  = 0;
  localparam int STA_PDC  = 3;
  localparam int STA_CC   = 4;
  localparam int STA_PDS  = 6;
  localparam int STA_LOCK = 7;

  localparam logic [15:0] CTL_WMASK = 16'h03F9;
  localparam logic [15:0] CTL_RESET = 16'h03C0;
  localparam logic [15:0] STA_W1C   = 16'h0019;
  localparam logic [15:0] EVT_MASK  = 16'h0019;

  typedef struct packed {
    logic       ctlWr;
    logic [1:0] ctlBe;
    logic       staWr;
    logic [1:0] staBe;
    logic       lockFlip;
    logic       pdsSet;
    logic       pdsClr;
    logic       pdcSet;
    logic       abpSet;
  } slotStrobe_t;

endpackage

// File: rtl/slot_hp_dp.sv
module slot_hp_dp
  import slot_hp_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SLOT_NUMBER = 42,
  parameter int SLOT_NUM_W  = 13,
  parameter int VEC_W       = 5,
  parameter int MSG_VECTOR  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobe_t       stb,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              lockEngaged,
  output logic              pendNow
);

  localparam logic [31:0] ID_WORD  = 32'(VEC_W'(MSG_VECTOR));
  localparam logic [31:0] CAP_WORD = {10'b0, 6'b111111, 3'b0, SLOT_NUM_W'(SLOT_NUMBER)};
  localparam int HALF_BYTES = 2;

  logic [15:0] ctlQ, ctlNext;
  logic [15:0] staQ, staNext;

  always_comb begin
    ctlNext = ctlQ;
    if (stb.ctlWr) begin
      for (int b = 0; b < HALF_BYTES; b++) begin
        if (stb.ctlBe[b]) begin
          ctlNext[b*8 +: 8] = (ctlQ[b*8 +: 8] & ~CTL_WMASK[b*8 +: 8])
                            | (wrData[b*8 +: 8] & CTL_WMASK[b*8 +: 8]);
        end
      end
    end
  end

  always_comb begin
    staNext = staQ;
    if (stb.staWr) begin
      for (int b = 0; b < HALF_BYTES; b++) begin
        if (stb.staBe[b]) begin
          staNext[b*8 +: 8] = staQ[b*8 +: 8] & ~(wrData[16 + b*8 +: 8] & STA_W1C[b*8 +: 8]);
        end
      end
    end
    if (stb.ctlWr)    staNext[STA_CC]   = 1'b1;
    if (stb.lockFlip) staNext[STA_LOCK] = ~staQ[STA_LOCK];
    if (stb.pdsSet)   staNext[STA_PDS]  = 1'b1;
    if (stb.pdsClr)   staNext[STA_PDS]  = 1'b0;
    if (stb.pdcSet)   staNext[STA_PDC]  = 1'b1;
    if (stb.abpSet)   staNext[STA_ABP]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= CTL_RESET;
      staQ <= '0;
    end else begin
      ctlQ <= ctlNext;
      staQ <= staNext;
    end
  end

  always_comb begin
    case (int'(rdAddr))
      REG_ID:   rdData = ID_WORD;
      REG_CAP:  rdData = CAP_WORD;
      REG_SLOT: rdData = {staQ, ctlQ};
      default:  rdData = '0;
    endcase
  end

  assign lockEngaged = staQ[STA_LOCK];
  assign pendNow     = ctlQ[CTL_HP_IE] && |(staQ & ctlQ & EVT_MASK);

endmodule

// File: rtl/slot_hp_ctl.sv
module slot_hp_ctl
  import slot_hp_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic              lockBitData,
  input  logic              coldPlug,
  input  logic              hotAdd,
  input  logic              hotRemove,
  input  logic              attnPress,
  input  logic              msiEn,
  input  logic              msixEn,
  input  logic              lockEngaged,
  input  logic              pendNow,
  output slotStrobe_t       stb,
  output logic              plugBusy,
  output logic              msgReq,
  output logic              intxOut
);

  logic wrSlot, plugReq, refuse, silentNext;
  logic silentQ, notifiedQ, busyQ, msgQ, intxQ;

  assign wrSlot  = cfgWrEn && (cfgAddr == ADDR_W'(REG_SLOT));
  assign plugReq = hotAdd || hotRemove;
  assign refuse  = plugReq && lockEngaged;

  always_comb begin
    stb          = '0;
    stb.ctlWr    = wrSlot && |cfgByteEn[1:0];
    stb.ctlBe    = cfgByteEn[1:0];
    stb.staWr    = wrSlot && |cfgByteEn[3:2];
    stb.staBe    = cfgByteEn[3:2];
    stb.lockFlip = wrSlot && cfgByteEn[1] && lockBitData;
    stb.pdsSet   = coldPlug || (hotAdd && !lockEngaged);
    stb.pdsClr   = hotRemove && !hotAdd && !lockEngaged;
    stb.pdcSet   = plugReq && !lockEngaged;
    stb.abpSet   = attnPress;
  end

  // a cycle whose only action is a status write updates pending silently
  assign silentNext = stb.staWr && !stb.ctlWr && !stb.pdcSet && !stb.abpSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      silentQ   <= 1'b0;
      notifiedQ <= 1'b0;
      busyQ     <= 1'b0;
      msgQ      <= 1'b0;
      intxQ     <= 1'b0;
    end else begin
      silentQ <= silentNext;
      busyQ   <= refuse;
      msgQ    <= 1'b0;
      if (pendNow != notifiedQ) begin
        notifiedQ <= pendNow;
        if (!silentQ) begin
          if (msixEn || msiEn) msgQ  <= 1'b1;
          else                 intxQ <= pendNow;
        end
      end
      if (silentQ && !msixEn && !msiEn && !pendNow) intxQ <= 1'b0;
    end
  end

  assign plugBusy = busyQ;
  assign msgReq   = msgQ;
  assign intxOut  = intxQ;

endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
  import slot_hp_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SLOT_NUMBER = 42,
  parameter int SLOT_NUM_W  = 13,
  parameter int VEC_W       = 5,
  parameter int MSG_VECTOR  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              coldPlug,
  input  logic              hotAdd,
  input  logic              hotRemove,
  input  logic              attnPress,
  input  logic              msiEn,
  input  logic              msixEn,
  output logic              plugBusy,
  output logic              msgReq,
  output logic [VEC_W-1:0]  msgVector,
  output logic              intxOut
);

  slotStrobe_t stb;
  logic lockEngaged, pendNow;

  slot_hp_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .lockBitData(cfgWrData[CTL_LOCK]),
    .coldPlug(coldPlug), .hotAdd(hotAdd), .hotRemove(hotRemove),
    .attnPress(attnPress), .msiEn(msiEn), .msixEn(msixEn),
    .lockEngaged(lockEngaged), .pendNow(pendNow), .stb(stb),
    .plugBusy(plugBusy), .msgReq(msgReq), .intxOut(intxOut)
  );

  slot_hp_dp #(
    .ADDR_W(ADDR_W), .SLOT_NUMBER(SLOT_NUMBER), .SLOT_NUM_W(SLOT_NUM_W),
    .VEC_W(VEC_W), .MSG_VECTOR(MSG_VECTOR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cfgWrData),
    .rdAddr(cfgAddr), .rdData(cfgRdData),
    .lockEngaged(lockEngaged), .pendNow(pendNow)
  );

  assign msgVector = VEC_W'(MSG_VECTOR);

endmodule

// File: rtl/slot_hp_checker.sv
module slot_hp_checker #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [3:0]        cfgByteEn,
  input logic [31:0]       cfgWrData,
  input logic [31:0]       cfgRdData,
  input logic              hotAdd,
  input logic              hotRemove,
  input logic              msiEn,
  input logic              msixEn,
  input logic              plugBusy,
  input logic              msgReq,
  input logic              intxOut
);

  localparam logic [ADDR_W-1:0] SLOT_IDX = ADDR_W'(2);

  // R3: a control-byte write leaves command completed set
  a_r3_cmd_done: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == SLOT_IDX && |cfgByteEn[1:0])
      |=> (cfgAddr != SLOT_IDX || cfgRdData[20]));

  // R4: interlock control flips interlock status
  a_r4_lock_flip: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == SLOT_IDX && cfgByteEn[1] && cfgWrData[11] && cfgAddr == SLOT_IDX)
      |=> (cfgAddr != SLOT_IDX || cfgRdData[23] != $past(cfgRdData[23])));

  // R8: busy only follows an insert or remove request
  a_r8_busy_cause: assert property (@(posedge clk) disable iff (!rstN)
    plugBusy |-> $past(hotAdd || hotRemove));

  // R9: a message only in a message mode
  a_r9_msg_mode: assert property (@(posedge clk) disable iff (!rstN)
    msgReq |-> $past(msiEn || msixEn));

  // R10: INTx rises only with both message modes off
  a_r10_intx_mode: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intxOut) |-> $past(!msiEn && !msixEn));

endmodule

bind slot_hp_ctrl slot_hp_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
  .hotAdd(hotAdd), .hotRemove(hotRemove), .msiEn(msiEn), .msixEn(msixEn),
  .plugBusy(plugBusy), .msgReq(msgReq), .intxOut(intxOut)
);

// File: tb/slot_hp_ctrl_tb.sv
module slot_hp_ctrl_tb_top;

  localparam int ADDR_W = 2;
  localparam int VEC_W  = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [3:0]       cfgByteEn = '0;
  logic [31:0]      cfgWrData = '0;
  logic [31:0]      cfgRdData;
  logic coldPlug = 1'b0, hotAdd = 1'b0, hotRemove = 1'b0, attnPress = 1'b0;
  logic msiEn = 1'b0, msixEn = 1'b0;
  logic plugBusy, msgReq, intxOut;
  logic [VEC_W-1:0] msgVector;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_hp_ctrl #(.ADDR_W(ADDR_W), .SLOT_NUMBER(42), .VEC_W(VEC_W), .MSG_VECTOR(9)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .coldPlug(coldPlug), .hotAdd(hotAdd), .hotRemove(hotRemove),
    .attnPress(attnPress), .msiEn(msiEn), .msixEn(msixEn),
    .plugBusy(plugBusy), .msgReq(msgReq), .msgVector(msgVector), .intxOut(intxOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cfgWrEn = 1'b0; cfgByteEn = '0; cfgWrData = '0; cfgAddr = 2'd2;
    coldPlug = 0; hotAdd = 0; hotRemove = 0; attnPress = 0; msiEn = 0; msixEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive a write for one edge; returns at the negedge after the update
  task automatic wr(input logic [3:0] be, input logic [31:0] data);
    cfgAddr = 2'd2; cfgWrEn = 1'b1; cfgByteEn = be; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0; cfgWrData = '0;
  endtask

  task automatic rdChk(input string req, input int addr, input logic [31:0] exp);
    cfgAddr = ADDR_W'(addr);
    #1;
    chk(req, cfgRdData, exp);
    cfgAddr = 2'd2;
  endtask

  // pulse: 0 cold, 1 add, 2 remove, 3 button
  task automatic pulse(input int kind);
    case (kind)
      0: coldPlug = 1'b1;
      1: hotAdd = 1'b1;
      2: hotRemove = 1'b1;
      default: attnPress = 1'b1;
    endcase
    @(negedge clk);
    coldPlug = 0; hotAdd = 0; hotRemove = 0; attnPress = 0;
  endtask

  task automatic testReset();
    doReset();
    rdChk("R1 slot regs", 2, 32'h000003C0);
    chk("R1 msgReq", {31'b0, msgReq}, 0);
    chk("R1 intx", {31'b0, intxOut}, 0);
    rdChk("R13 id word", 0, 32'd9);
    rdChk("R13 cap word", 1, 32'h003F002A);
    rdChk("R13 unused word", 3, 32'h0);
  endtask

  task automatic testMask();
    doReset();
    wr(4'b0011, 32'h0000F406);
    rdChk("R2 mask and R3 cmd done", 2, 32'h00100000);
    wr(4'b1100, 32'h00100000);
    rdChk("R5 clear cmd done", 2, 32'h00000000);
    wr(4'b0100, 32'h00000000);
    rdChk("R3 status-only write no cmd", 2, 32'h00000000);
  endtask

  task automatic testLock();
    doReset();
    wr(4'b0010, 32'h00000B00);
    rdChk("R4 lock set, bit11 reads 0", 2, 32'h009003C0);
    wr(4'b0010, 32'h00000B00);
    rdChk("R4 lock cleared", 2, 32'h001003C0);
  endtask

  task automatic testEvents();
    doReset();
    pulse(0);
    rdChk("R6 cold plug", 2, 32'h004003C0);
    pulse(2);
    rdChk("R7 remove", 2, 32'h000803C0);
    pulse(3);
    rdChk("R7 button", 2, 32'h000903C0);
    pulse(1);
    rdChk("R7 insert", 2, 32'h004903C0);
    wr(4'b1100, 32'h00010000);
    rdChk("R5 clear button only", 2, 32'h004803C0);
    wr(4'b1100, 32'hFFFF0000);
    rdChk("R5 presence state kept", 2, 32'h004003C0);
  endtask

  task automatic testBusy();
    doReset();
    wr(4'b0010, 32'h00000B00);
    pulse(1);
    chk("R8 busy on insert", {31'b0, plugBusy}, 1);
    rdChk("R8 status unchanged", 2, 32'h009003C0);
    wr(4'b0010, 32'h00000B00);
    pulse(1);
    chk("R8 no busy when unlocked", {31'b0, plugBusy}, 0);
    rdChk("R7 insert after unlock", 2, 32'h005803C0);
  endtask

  task automatic testMsg();
    doReset();
    msiEn = 1'b1;
    wr(4'b0001, 32'h000000E8);
    chk("R9 no pending yet", {31'b0, msgReq}, 0);
    @(negedge clk);
    chk("R9 no pending yet 2", {31'b0, msgReq}, 0);
    pulse(1);
    chk("R9 not before second edge", {31'b0, msgReq}, 0);
    @(negedge clk);
    chk("R9 msg pulse", {31'b0, msgReq}, 1);
    chk("R9 vector", {27'b0, msgVector}, 9);
    @(negedge clk);
    chk("R9 one cycle", {31'b0, msgReq}, 0);
    pulse(2);
    @(negedge clk);
    chk("R11 repeat event silent", {31'b0, msgReq}, 0);
    @(negedge clk);
    chk("R11 repeat event silent 2", {31'b0, msgReq}, 0);
    wr(4'b1100, 32'h00080000);
    @(negedge clk);
    chk("R11 clear silent", {31'b0, msgReq}, 0);
    msiEn = 1'b0; msixEn = 1'b1;
    pulse(1);
    @(negedge clk);
    chk("R9 msg in extended mode", {31'b0, msgReq}, 1);
    chk("R10 intx stays low in msg mode", {31'b0, intxOut}, 0);
  endtask

  task automatic testIntx();
    doReset();
    wr(4'b0001, 32'h000000F8);
    @(negedge clk);
    chk("R10 intx high", {31'b0, intxOut}, 1);
    chk("R10 no msg", {31'b0, msgReq}, 0);
    wr(4'b1100, 32'h00100000);
    @(negedge clk);
    chk("R10 intx low after clear", {31'b0, intxOut}, 0);
  endtask

  task automatic testDefer();
    doReset();
    msiEn = 1'b1;
    pulse(3);
    @(negedge clk);
    chk("R12 no msg while disabled", {31'b0, msgReq}, 0);
    wr(4'b0001, 32'h000000E1);
    @(negedge clk);
    chk("R12 msg after enable", {31'b0, msgReq}, 1);
    @(negedge clk);
    chk("R12 single msg", {31'b0, msgReq}, 0);
  endtask

  initial begin
    testReset();
    testMask();
    testLock();
    testEvents();
    testBusy();
    testMsg();
    testIntx();
    testDefer();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule